// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

This block holds a parallel word in a storage register and passes it into a parallel-in, serial-out shift register. The serial output is the last stage of the shift register. The storage register and the shift register each have their own strobe. There is also a serial data input, an active-low control that copies storage into the shift stages, and an active-low control that clears the shift stages.

All logic runs on one fast system clock. The two strobes and the serial input arrive asynchronously and pass through a two-flop synchroniser. A rising edge on a synchronised strobe is detected by comparing the current and previous samples. The detection is registered, and the update happens on the next clock. Because of this, the register update follows the input strobe edge by three clock edges after the edge that first samples it. The copy and clear controls are level controls that are synchronous to the system clock, and they override shifting.

Driving both controls low at once is invalid. The block handles that case by clearing the shift stages and setting a sticky error flag.

Top module: `piso_latch_shifter`

## Requirements
- R1: After reset, every shift stage and every storage bit is 0, `ser_out` is 0 and `cfg_err` is 0.
- R2: A rising edge on `store_stb` loads `par_in` into the storage register, whatever the levels of `copy_n`, `clear_n` and `shift_stb`. The storage register does not change at any other time.
- R3: While `copy_n` is low and `clear_n` is high, the shift register takes the storage contents on every clock, with no `shift_stb` edge needed.
- R4: A `store_stb` edge acted on while `copy_n` is low and `clear_n` is high puts `par_in` into the shift register in the same clock in which it enters storage. With `store_stb` driven high just before clock edge k, `ser_out` shows the new word's bit 7 after edge k+3 and not before.
- R5: While `clear_n` is low and `copy_n` is high, all shift stages go to 0, and `shift_stb` edges have no effect.
- R6: With both controls high, each acted-on `shift_stb` rising edge moves stage n to stage n+1 and loads `ser_in` into stage 0. `ser_out` is stage 7, so a copied word comes out bit 7 first.
- R7: When `copy_n` and `clear_n` are low together, the shift stages go to 0 and `cfg_err` goes to 1. `cfg_err` then stays 1 until reset.
- R8: A `shift_stb` edge acted on while `copy_n` is low does not shift; the copy wins.
- R9: A `shift_stb` held high for many clocks causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| par_in | input | 8 | Parallel data word |
| store_stb | input | 1 | Storage strobe, acts on its rising edge (asynchronous) |
| shift_stb | input | 1 | Shift strobe, acts on its rising edge (asynchronous) |
| ser_in | input | 1 | Serial data into stage 0 (asynchronous) |
| copy_n | input | 1 | Active-low level control: copy storage into the shift register |
| clear_n | input | 1 | Active-low level control: clear the shift register |
| ser_out | output | 1 | Serial output, shift stage 7 |
| cfg_err | output | 1 | Sticky flag for the invalid copy-plus-clear combination |

## Verification
Words are read back by shifting them out through `ser_out`. Words with an asymmetric bit pattern, such as 0xA5, 0xC3, 0x5A and 0x96, show whether the bit order is reversed or a stage is dropped.

The storage strobe is exercised in three ways: with clear held, with copy released, and with copy held. This separates capture into storage from transfer into the shift register. The copy-held case is sampled at edges k+2 and k+3 to tell the same-update bypass apart from a copy one clock late. A strobe held high, and a strobe that rises while copy is held, show whether the edge detector fires once per edge and whether the copy takes priority.

// File: rtl/piso_pkg.sv
package piso_pkg;

  typedef enum logic [2:0] {
    SR_HOLD,
    SR_CLEAR,
    SR_FAULT,
    SR_COPY,
    SR_BYPASS,
    SR_SHIFT
  } sr_mode_e;

  // Priority: invalid combination, then clear, then copy, then shift.
  function automatic sr_mode_e sr_decode(input logic copy_n,
                                         input logic clear_n,
                                         input logic store_ev,
                                         input logic shift_ev);
    sr_mode_e m;
    if (!clear_n && !copy_n)      m = SR_FAULT;
    else if (!clear_n)            m = SR_CLEAR;
    else if (!copy_n)             m = store_ev ? SR_BYPASS : SR_COPY;
    else if (shift_ev)            m = SR_SHIFT;
    else                          m = SR_HOLD;
    return m;
  endfunction

endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/piso_bit_sync.sv
module piso_bit_sync #(
  parameter int N     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [DEPTH-1:0] chain_q;
    logic [DEPTH-1:0] chain_d;

    always_comb chain_d = {chain_q[DEPTH-2:0], d_async[i]};

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= chain_d;
    end

    assign q_sync[i] = chain_q[DEPTH-1];
  end
endmodule

// File: rtl/piso_edge_detect.sv
module piso_edge_detect #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] stb_async,
  output logic [N-1:0] rise_q
);
  logic [N-1:0] lvl;
  logic [N-1:0] prev_q;
  logic [N-1:0] rise_d;

  piso_bit_sync #(.N(N), .DEPTH(STAGES)) u_sync (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .d_async (stb_async),
    .q_sync  (lvl)
  );

  always_comb rise_d = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      rise_q <= '0;
    end else begin
      prev_q <= lvl;
      rise_q <= rise_d;
    end
  end
endmodule

// File: rtl/piso_store_reg.sv
module piso_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         store_ev,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] store_q
);
  logic         st_en;
  logic [W-1:0] st_d;

  always_comb begin
    st_en = store_ev;
    st_d  = par_in;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    store_q <= '0;
    else if (st_en) store_q <= st_d;
  end
endmodule

// File: rtl/piso_shift_core.sv
module piso_shift_core
  import piso_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] store_q,
  input  logic [W-1:0] par_in,
  input  logic         store_ev,
  input  logic         shift_ev,
  input  logic         ser_bit,
  input  logic         copy_n,
  input  logic         clear_n,
  output logic [W-1:0] shift_q,
  output logic         err_q
);
  sr_mode_e     mode;
  logic [W-1:0] shifted;
  logic [W-1:0] sh_d;
  logic         sh_en;
  logic         err_d;

  assign shifted[0] = ser_bit;
  for (genvar g = 1; g < W; g++) begin : g_stage
    assign shifted[g] = shift_q[g-1];
  end

  always_comb begin
    mode  = sr_decode(copy_n, clear_n, store_ev, shift_ev);
    sh_en = 1'b1;
    sh_d  = shift_q;
    unique case (mode)
      SR_FAULT,
      SR_CLEAR:  sh_d = '0;
      SR_COPY:   sh_d = store_q;
      SR_BYPASS: sh_d = par_in;
      SR_SHIFT:  sh_d = shifted;
      default:   sh_en = 1'b0;
    endcase
    err_d = err_q | (mode == SR_FAULT);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (sh_en) shift_q <= sh_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/piso_latch_shifter.sv
module piso_latch_shifter #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  input  logic         store_stb,
  input  logic         shift_stb,
  input  logic         ser_in,
  input  logic         copy_n,
  input  logic         clear_n,
  output logic         ser_out,
  output logic         cfg_err
);
  localparam int NSTB    = 2;
  localparam int IX_ST   = 0;
  localparam int IX_SH   = 1;
  localparam int SER_DLY = SYNC_STAGES + 1;

  logic            rst_ni;
  logic [NSTB-1:0] stb_rise;
  logic            store_ev;
  logic            shift_ev;
  logic            ser_bit;
  logic [W-1:0]    store_q;
  logic [W-1:0]    shift_q;

  piso_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  piso_edge_detect #(.N(NSTB), .STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .stb_async ({shift_stb, store_stb}),
    .rise_q    (stb_rise)
  );

  assign store_ev = stb_rise[IX_ST];
  assign shift_ev = stb_rise[IX_SH];

  // Serial data delayed to line up with the registered shift edge.
  piso_bit_sync #(.N(1), .DEPTH(SER_DLY)) u_ser (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .d_async (ser_in),
    .q_sync  (ser_bit)
  );

  piso_store_reg #(.W(W)) u_store (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .store_ev (store_ev),
    .par_in   (par_in),
    .store_q  (store_q)
  );

  piso_shift_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .store_q  (store_q),
    .par_in   (par_in),
    .store_ev (store_ev),
    .shift_ev (shift_ev),
    .ser_bit  (ser_bit),
    .copy_n   (copy_n),
    .clear_n  (clear_n),
    .shift_q  (shift_q),
    .err_q    (cfg_err)
  );

  assign ser_out = shift_q[W-1];
endmodule

// File: rtl/piso_latch_shifter_chk.sv
module piso_latch_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         copy_n,
  input logic         clear_n,
  input logic         store_ev,
  input logic         shift_ev,
  input logic         ser_bit,
  input logic [W-1:0] store_q,
  input logic [W-1:0] shift_q,
  input logic         cfg_err
);
  p_store_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !store_ev |=> $stable(store_q));

  p_copy_level_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_n && !copy_n && !store_ev) |=> (shift_q == $past(store_q)));

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_n && !copy_n && store_ev) |=> (shift_q == store_q));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear_n) |=> (shift_q == '0));

  p_shift_step_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_n && copy_n && shift_ev) |=>
      (shift_q == {$past(shift_q[W-2:0]), $past(ser_bit)}));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_n && copy_n && !shift_ev) |=> $stable(shift_q));

  p_fault_flag_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear_n && !copy_n) |=> cfg_err);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_err |=> cfg_err);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    shift_ev |=> !shift_ev);
endmodule

bind piso_latch_shifter piso_latch_shifter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .copy_n   (copy_n),
  .clear_n  (clear_n),
  .store_ev (store_ev),
  .shift_ev (shift_ev),
  .ser_bit  (ser_bit),
  .store_q  (store_q),
  .shift_q  (shift_q),
  .cfg_err  (cfg_err)
);

// File: tb/piso_latch_shifter_test.sv
`timescale 1ns/1ps
module piso_latch_shifter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] par_in;
  logic       store_stb, shift_stb, ser_in, copy_n, clear_n;
  logic       ser_out, cfg_err;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       done  = 1'b0;

  always #5 clk = ~clk;

  piso_latch_shifter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_in    (par_in),
    .store_stb (store_stb),
    .shift_stb (shift_stb),
    .ser_in    (ser_in),
    .copy_n    (copy_n),
    .clear_n   (clear_n),
    .ser_out   (ser_out),
    .cfg_err   (cfg_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic pulse_store();
    store_stb = 1'b1; step(6);
    store_stb = 1'b0; step(6);
  endtask

  task automatic shift_once(input logic b);
    ser_in = b; step(3);
    shift_stb = 1'b1; step(6);
    shift_stb = 1'b0; step(6);
  endtask

  // Reads the shift register out through ser_out, bit 7 first (copy_n, clear_n high).
  task automatic read_word(output logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin
      w[i] = ser_out;
      shift_once(1'b0);
    end
  endtask

  task automatic t_reset();
    logic [7:0] w;
    check("R1 ser_out", {7'd0, ser_out}, 8'h00);
    check("R1 cfg_err", {7'd0, cfg_err}, 8'h00);
    read_word(w);
    check("R1 shift contents", w, 8'h00);
    copy_n = 1'b0; step(1); copy_n = 1'b1;
    read_word(w);
    check("R1 storage contents", w, 8'h00);
  endtask

  task automatic t_store_any();
    logic [7:0] w;
    clear_n = 1'b0; par_in = 8'hA5;
    shift_stb = 1'b1;
    pulse_store();
    shift_stb = 1'b0;
    par_in = 8'h00; step(4);
    clear_n = 1'b1; step(2);
    copy_n = 1'b0; step(2); copy_n = 1'b1;
    read_word(w);
    check("R2 captured during clear", w, 8'hA5);
  endtask

  task automatic t_copy_level();
    logic [7:0] w;
    par_in = 8'hC3;
    pulse_store();
    check("R3 no copy while copy_n high", {7'd0, ser_out}, 8'h00);
    copy_n = 1'b0; step(1);
    check("R3 copy without strobe", {7'd0, ser_out}, 8'h01);
    copy_n = 1'b1;
    read_word(w);
    check("R3 copied word, R6 msb first", w, 8'hC3);
  endtask

  task automatic t_bypass();
    logic [7:0] w;
    copy_n = 1'b0; step(2);
    check("R3 held copy", {7'd0, ser_out}, 8'h01);
    par_in = 8'h5A;
    store_stb = 1'b1;
    step(3);
    check("R4 not before edge k+3", {7'd0, ser_out}, 8'h01);
    step(1);
    check("R4 bypass at edge k+3", {7'd0, ser_out}, 8'h00);
    step(4); store_stb = 1'b0; step(6);
    copy_n = 1'b1;
    read_word(w);
    check("R4 bypassed word", w, 8'h5A);
  endtask

  task automatic t_clear();
    logic [7:0] w;
    copy_n = 1'b0; step(1); copy_n = 1'b1;
    clear_n = 1'b0;
    shift_once(1'b1);
    shift_once(1'b1);
    clear_n = 1'b1; step(2);
    read_word(w);
    check("R5 cleared, shifts ignored", w, 8'h00);
    check("R5 no error flag", {7'd0, cfg_err}, 8'h00);
  endtask

  task automatic t_shift();
    logic [7:0] w;
    logic [7:0] pat = 8'h96;
    for (int i = 7; i >= 0; i--) shift_once(pat[i]);
    read_word(w);
    check("R6 serial fill", w, 8'h96);
  endtask

  task automatic t_copy_wins();
    logic [7:0] w;
    copy_n = 1'b0;
    shift_once(1'b1);
    copy_n = 1'b1; step(2);
    read_word(w);
    check("R8 copy beats shift", w, 8'h5A);
  endtask

  task automatic t_held_strobe();
    logic [7:0] w;
    copy_n = 1'b0; step(1); copy_n = 1'b1;
    ser_in = 1'b1; step(3);
    shift_stb = 1'b1; step(30);
    shift_stb = 1'b0; ser_in = 1'b0; step(6);
    read_word(w);
    check("R9 single shift on held strobe", w, 8'hB5);
  endtask

  task automatic t_invalid();
    logic [7:0] w;
    copy_n = 1'b0; step(1); copy_n = 1'b1;
    check("R7 preload", {7'd0, ser_out}, 8'h00);
    par_in = 8'hFF; pulse_store();
    copy_n = 1'b0; step(1); copy_n = 1'b1;
    check("R7 preload ones", {7'd0, ser_out}, 8'h01);
    copy_n = 1'b0; clear_n = 1'b0; step(2);
    check("R7 flag set", {7'd0, cfg_err}, 8'h01);
    check("R7 stages zero", {7'd0, ser_out}, 8'h00);
    copy_n = 1'b1; clear_n = 1'b1; step(3);
    read_word(w);
    check("R7 contents after release", w, 8'h00);
    check("R7 flag sticky", {7'd0, cfg_err}, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; par_in = 8'h00;
    store_stb = 1'b0; shift_stb = 1'b0; ser_in = 1'b0;
    copy_n = 1'b1; clear_n = 1'b1;
    step(4);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_store_any();
    t_copy_level();
    t_bypass();
    t_clear();
    t_shift();
    t_copy_wins();
    t_held_strobe();
    t_invalid();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule